// File: doc/BRIEF.md
# Power-Up and Fault Reset Sequencer

This block controls system reset for a small 8-bit microcontroller. It runs on the reference clock. A power-on event starts the long path. Internal clocks stay gated off for a fixed oscillator settling interval, and the open-drain reset pin is pulled low for that whole interval. After that, two short release phases run with the clocks enabled. The sequencer then puts the two reset-vector addresses on the address bus, high byte first, and hands over to normal execution.

A watchdog overflow or an illegal-opcode indication from the CPU starts the short path. The settling stall is skipped and only the two short phases and the vector fetch run. A cause register records which event produced the most recent reset. Its contents are always visible to the CPU, and reading them changes nothing. The power-on input also serves as the block's synchronous, active-high reset.

Top module: `rst_seq_ctrl`

## Requirements
- R1: In the cycle after a clock edge that samples `pwr_on_i` high, the outputs are as follows: `int_rst_o`=1, `pin_lo_o`=1, `clk_en_o`=0, `vec_vld_o`=0, `vec_addr_o`=0, and `cause_o`=8'h01 (bit 0 = power-on, all other bits 0).
- R2: After the last edge that samples `pwr_on_i` high, `clk_en_o` stays 0 for exactly STALL_CYC (4096) cycles. During those cycles `int_rst_o` and `pin_lo_o` stay 1.
- R3: `pin_lo_o` is 1 during the stall and during the first short phase, and 0 during the second short phase. `pin_lo_o` is never 1 while `int_rst_o` is 0.
- R4: Two phases of PHASE_CYC (32) cycles each follow the stall. In both, `clk_en_o`=1 and `int_rst_o`=1.
- R5: After the second phase comes one cycle with `vec_vld_o`=1 and `vec_addr_o`=16'hFFFE, then one cycle with `vec_vld_o`=1 and `vec_addr_o`=16'hFFFF. `int_rst_o` is 0 in both cycles. The block then stays in run state: `vec_vld_o`=0, `vec_addr_o`=0, `int_rst_o`=0, `clk_en_o`=1.
- R6: A watchdog request (`wdog_ovf_i`=1 at an edge) sets `cause_o` to 8'h02 (bit 1 = watchdog, others cleared). The sequence restarts at the first cycle of the first short phase, with no stall.
- R7: An illegal-opcode request (`bad_op_i`=1) sets `cause_o` to 8'h04 (bit 2). If both requests arrive at the same edge, `cause_o` becomes 8'h06. Either way the same short sequence as in R6 starts.
- R8: A request that arrives during a short phase or a vector cycle restarts the sequence from the first cycle of the first short phase. It replaces the cause flags.
- R9: Requests that arrive while the clocks are stalled are ignored. The stall length and `cause_o` are unchanged.
- R10: When `pwr_on_i` and an internal request are sampled at the same edge, power-on wins. The stall starts and `cause_o` becomes 8'h01.
- R11: Without a power-on or internal request, `cause_o` holds its value indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| pwr_on_i | input | 1 | Power-on event; also the synchronous active-high block reset |
| wdog_ovf_i | input | 1 | Watchdog overflow request |
| bad_op_i | input | 1 | Illegal-opcode request from the CPU |
| int_rst_o | output | 1 | Internal reset to CPU and peripherals |
| pin_lo_o | output | 1 | Enable for the open-drain pull-down on the external reset pin |
| clk_en_o | output | 1 | Enable for CPU and peripheral clocks |
| vec_vld_o | output | 1 | The sequencer is driving a reset-vector address |
| vec_addr_o | output | 16 | Reset-vector address (0 when not valid) |
| cause_o | output | 8 | Reset cause flags: bit 0 power-on, bit 1 watchdog, bit 2 illegal opcode |

## Verification
The bench samples both sides of each boundary: the 4095th and 4096th stall cycle, and the last and first cycle of each 32-cycle phase. An off-by-one counter would shift clock enable or pin release by a cycle. A request sent during the stall checks that a design which honoured it does not cut the oscillator wait short or overwrite the power-on flag. Requests sent mid-phase and during a vector fetch check that a design which resumed the old count, or merged flags instead of replacing them, is caught. A power-on arriving together with a watchdog request checks the priority between the two paths.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    typedef enum logic [2:0] {
        PH_STALL,
        PH_DRIVE,
        PH_SETTLE,
        PH_VEC_HI,
        PH_VEC_LO,
        PH_RUN
    } phase_e;

    typedef struct packed {
        logic [4:0] rsvd;
        logic       bad_op;
        logic       wdog;
        logic       pwr;
    } cause_t;

    typedef struct packed {
        logic        int_rst;
        logic        pin_lo;
        logic        clk_en;
        logic        vec_vld;
        logic [15:0] addr;
    } drive_t;

    localparam cause_t CAUSE_PWR = '{rsvd: 5'd0, bad_op: 1'b0, wdog: 1'b0, pwr: 1'b1};

    function automatic drive_t phase_drive(phase_e ph, logic [15:0] hi_a, logic [15:0] lo_a);
        drive_t d;
        d = '{int_rst: 1'b0, pin_lo: 1'b0, clk_en: 1'b1, vec_vld: 1'b0, addr: 16'h0000};
        case (ph)
            PH_STALL:  begin d.int_rst = 1'b1; d.pin_lo = 1'b1; d.clk_en = 1'b0; end
            PH_DRIVE:  begin d.int_rst = 1'b1; d.pin_lo = 1'b1; end
            PH_SETTLE: d.int_rst = 1'b1;
            PH_VEC_HI: begin d.vec_vld = 1'b1; d.addr = hi_a; end
            PH_VEC_LO: begin d.vec_vld = 1'b1; d.addr = lo_a; end
            default:   ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
    import rst_seq_pkg::*;
#(
    parameter int STALL_CYC = 4096,
    parameter int PHASE_CYC = 32
) (
    input  logic   clk,
    input  logic   por_i,
    input  logic   req_i,
    output phase_e phase_o,
    output logic   take_o
);
    localparam int LONGEST = (STALL_CYC > PHASE_CYC) ? STALL_CYC : PHASE_CYC;
    localparam int CNT_W   = (LONGEST > 1) ? $clog2(LONGEST) : 1;
    localparam logic [CNT_W-1:0] STALL_LAST = CNT_W'(STALL_CYC - 1);
    localparam logic [CNT_W-1:0] PHASE_LAST = CNT_W'(PHASE_CYC - 1);

    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;

    // requests are not honoured while clocks are gated (R9)
    assign take_o  = req_i && (phase_q != PH_STALL);
    assign phase_o = phase_q;

    always_ff @(posedge clk) begin
        if (por_i) begin
            phase_q <= PH_STALL;
            cnt_q   <= '0;
        end else if (take_o) begin
            phase_q <= PH_DRIVE;
            cnt_q   <= '0;
        end else begin
            case (phase_q)
                PH_STALL: begin
                    if (cnt_q == STALL_LAST) begin
                        phase_q <= PH_DRIVE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                PH_DRIVE, PH_SETTLE: begin
                    if (cnt_q == PHASE_LAST) begin
                        phase_q <= (phase_q == PH_DRIVE) ? PH_SETTLE : PH_VEC_HI;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                PH_VEC_HI: phase_q <= PH_VEC_LO;
                PH_VEC_LO: phase_q <= PH_RUN;
                default:   phase_q <= PH_RUN;
            endcase
        end
    end
endmodule

// File: rtl/rst_seq_cause.sv
module rst_seq_cause
    import rst_seq_pkg::*;
(
    input  logic   clk,
    input  logic   por_i,
    input  logic   take_i,
    input  logic   wdog_i,
    input  logic   bad_op_i,
    output cause_t cause_o
);
    cause_t cause_q;

    always_ff @(posedge clk) begin
        if (por_i) begin
            cause_q <= CAUSE_PWR;
        end else if (take_i) begin
            cause_q <= '{rsvd: 5'd0, bad_op: bad_op_i, wdog: wdog_i, pwr: 1'b0};
        end
    end

    assign cause_o = cause_q;
endmodule

// File: rtl/rst_seq_outdec.sv
module rst_seq_outdec
    import rst_seq_pkg::*;
#(
    parameter logic [15:0] VEC_HI_ADDR = 16'hFFFE,
    parameter logic [15:0] VEC_LO_ADDR = 16'hFFFF
) (
    input  phase_e phase_i,
    output drive_t drive_o
);
    always_comb begin
        drive_o = phase_drive(phase_i, VEC_HI_ADDR, VEC_LO_ADDR);
    end
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
    import rst_seq_pkg::*;
#(
    parameter int          STALL_CYC   = 4096,
    parameter int          PHASE_CYC   = 32,
    parameter logic [15:0] VEC_HI_ADDR = 16'hFFFE,
    parameter logic [15:0] VEC_LO_ADDR = 16'hFFFF
) (
    input  logic        clk,
    input  logic        pwr_on_i,
    input  logic        wdog_ovf_i,
    input  logic        bad_op_i,
    output logic        int_rst_o,
    output logic        pin_lo_o,
    output logic        clk_en_o,
    output logic        vec_vld_o,
    output logic [15:0] vec_addr_o,
    output logic [7:0]  cause_o
);
    phase_e phase;
    logic   take;
    cause_t cause;
    drive_t drv;

    rst_seq_fsm #(.STALL_CYC(STALL_CYC), .PHASE_CYC(PHASE_CYC)) fsm_i (
        .clk     (clk),
        .por_i   (pwr_on_i),
        .req_i   (wdog_ovf_i | bad_op_i),
        .phase_o (phase),
        .take_o  (take)
    );

    rst_seq_cause cause_i (
        .clk      (clk),
        .por_i    (pwr_on_i),
        .take_i   (take),
        .wdog_i   (wdog_ovf_i),
        .bad_op_i (bad_op_i),
        .cause_o  (cause)
    );

    rst_seq_outdec #(.VEC_HI_ADDR(VEC_HI_ADDR), .VEC_LO_ADDR(VEC_LO_ADDR)) dec_i (
        .phase_i (phase),
        .drive_o (drv)
    );

    assign int_rst_o  = drv.int_rst;
    assign pin_lo_o   = drv.pin_lo;
    assign clk_en_o   = drv.clk_en;
    assign vec_vld_o  = drv.vec_vld;
    assign vec_addr_o = drv.addr;
    assign cause_o    = cause;
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk (
    input logic        clk,
    input logic        pwr_on_i,
    input logic        wdog_ovf_i,
    input logic        bad_op_i,
    input logic        int_rst_o,
    input logic        pin_lo_o,
    input logic        clk_en_o,
    input logic        vec_vld_o,
    input logic [15:0] vec_addr_o,
    input logic [7:0]  cause_o
);
    assert_pin_needs_rst_R3: assert property (@(posedge clk) disable iff (pwr_on_i)
        pin_lo_o |-> int_rst_o);

    assert_stall_holds_rst_R2: assert property (@(posedge clk) disable iff (pwr_on_i)
        !clk_en_o |-> (int_rst_o && pin_lo_o));

    assert_vec_order_R5: assert property (@(posedge clk) disable iff (pwr_on_i)
        (vec_vld_o && vec_addr_o == 16'hFFFE && !wdog_ovf_i && !bad_op_i)
        |=> (vec_vld_o && vec_addr_o == 16'hFFFF));

    assert_vec_no_rst_R5: assert property (@(posedge clk) disable iff (pwr_on_i)
        vec_vld_o |-> !int_rst_o);

    assert_req_restarts_R6: assert property (@(posedge clk) disable iff (pwr_on_i)
        ((wdog_ovf_i || bad_op_i) && clk_en_o) |=> (int_rst_o && pin_lo_o && clk_en_o));

    assert_req_flags_R7: assert property (@(posedge clk) disable iff (pwr_on_i)
        ((wdog_ovf_i || bad_op_i) && clk_en_o)
        |=> (cause_o == {5'd0, $past(bad_op_i), $past(wdog_ovf_i), 1'b0}));

    assert_stall_ignores_req_R9: assert property (@(posedge clk) disable iff (pwr_on_i)
        !clk_en_o |=> $stable(cause_o));

    assert_cause_holds_R11: assert property (@(posedge clk) disable iff (pwr_on_i)
        (!wdog_ovf_i && !bad_op_i) |=> $stable(cause_o));
endmodule

bind rst_seq_ctrl rst_seq_chk chk_i (
    .clk        (clk),
    .pwr_on_i   (pwr_on_i),
    .wdog_ovf_i (wdog_ovf_i),
    .bad_op_i   (bad_op_i),
    .int_rst_o  (int_rst_o),
    .pin_lo_o   (pin_lo_o),
    .clk_en_o   (clk_en_o),
    .vec_vld_o  (vec_vld_o),
    .vec_addr_o (vec_addr_o),
    .cause_o    (cause_o)
);

// File: tb/rst_seq_ctrl_tb_top.sv
module rst_seq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        pwr_on_i = 1'b1;
    logic        wdog_ovf_i = 1'b0;
    logic        bad_op_i = 1'b0;
    logic        int_rst_o, pin_lo_o, clk_en_o, vec_vld_o;
    logic [15:0] vec_addr_o;
    logic [7:0]  cause_o;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    rst_seq_ctrl dut_i (
        .clk(clk), .pwr_on_i(pwr_on_i), .wdog_ovf_i(wdog_ovf_i), .bad_op_i(bad_op_i),
        .int_rst_o(int_rst_o), .pin_lo_o(pin_lo_o), .clk_en_o(clk_en_o),
        .vec_vld_o(vec_vld_o), .vec_addr_o(vec_addr_o), .cause_o(cause_o)
    );

    // flags field order: int_rst, pin_lo, clk_en, vec_vld
    typedef struct packed {
        logic [1:0]  kind;   // bit0 watchdog, bit1 illegal opcode
        logic [7:0]  k;      // edges after the request edge
        logic [3:0]  flags;
        logic [15:0] addr;
        logic [7:0]  cause;
    } vec_t;

    localparam vec_t TBL [8] = '{
        '{2'b01, 8'd0,   4'b1110, 16'h0000, 8'h02},   // R6 first drive cycle
        '{2'b01, 8'd31,  4'b1110, 16'h0000, 8'h02},   // R4 last drive cycle
        '{2'b10, 8'd32,  4'b1010, 16'h0000, 8'h04},   // R7 R3 settle starts
        '{2'b10, 8'd63,  4'b1010, 16'h0000, 8'h04},   // R4 last settle cycle
        '{2'b01, 8'd64,  4'b0011, 16'hFFFE, 8'h02},   // R5 high vector
        '{2'b10, 8'd65,  4'b0011, 16'hFFFF, 8'h04},   // R5 low vector
        '{2'b11, 8'd66,  4'b0010, 16'h0000, 8'h06},   // R7 both, run state
        '{2'b01, 8'd100, 4'b0010, 16'h0000, 8'h02}    // R11 cause held
    };

    task automatic check(input string req, input logic [3:0] f, input logic [15:0] a,
                         input logic [7:0] c);
        logic [27:0] got, exp;
        got = {int_rst_o, pin_lo_o, clk_en_o, vec_vld_o, vec_addr_o, cause_o};
        exp = {f, a, c};
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got flags=%b addr=%h cause=%h, expected flags=%b addr=%h cause=%h",
                     req, got[27:24], got[23:8], got[7:0], f, a, c);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse(input logic w, input logic b);
        wdog_ovf_i = w;
        bad_op_i   = b;
        @(posedge clk);
        @(negedge clk);
        wdog_ovf_i = 1'b0;
        bad_op_i   = 1'b0;
    endtask

    task automatic power_on();
        @(negedge clk);
        pwr_on_i = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 power-on state", 4'b1100, 16'h0, 8'h01);
        pwr_on_i = 1'b0;
    endtask

    initial begin
        // R1 R2 R3 R4 R5: full power-on sequence
        power_on();
        step(4095);
        check("R2 last stall cycle", 4'b1100, 16'h0, 8'h01);
        step(1);
        check("R2 R4 first drive cycle", 4'b1110, 16'h0, 8'h01);
        step(31);
        check("R3 last drive cycle", 4'b1110, 16'h0, 8'h01);
        step(1);
        check("R3 pin released in settle", 4'b1010, 16'h0, 8'h01);
        step(31);
        check("R4 last settle cycle", 4'b1010, 16'h0, 8'h01);
        step(1);
        check("R5 high vector", 4'b0011, 16'hFFFE, 8'h01);
        step(1);
        check("R5 low vector", 4'b0011, 16'hFFFF, 8'h01);
        step(1);
        check("R5 run state", 4'b0010, 16'h0, 8'h01);
        step(50);
        check("R11 cause kept after power-on", 4'b0010, 16'h0, 8'h01);

        // table walk of internal requests
        foreach (TBL[i]) begin
            pulse(TBL[i].kind[0], TBL[i].kind[1]);
            if (TBL[i].k != 0) step(int'(TBL[i].k));
            check($sformatf("R6/R7 table %0d", i), TBL[i].flags, TBL[i].addr, TBL[i].cause);
            step(120);
        end

        // R10: power-on together with watchdog
        @(negedge clk);
        pwr_on_i = 1'b1;
        wdog_ovf_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        pwr_on_i = 1'b0;
        wdog_ovf_i = 1'b0;
        check("R10 power-on wins", 4'b1100, 16'h0, 8'h01);

        // R9: request during stall ignored
        step(100);
        pulse(1'b1, 1'b0);
        check("R9 cause unchanged in stall", 4'b1100, 16'h0, 8'h01);
        step(3994);
        check("R9 stall length unchanged", 4'b1100, 16'h0, 8'h01);
        step(1);
        check("R9 drive after full stall", 4'b1110, 16'h0, 8'h01);

        // R8: restart during settle phase
        step(40);
        check("R8 in settle", 4'b1010, 16'h0, 8'h01);
        pulse(1'b0, 1'b1);
        check("R8 restart to drive", 4'b1110, 16'h0, 8'h04);
        step(31);
        check("R8 full drive phase after restart", 4'b1110, 16'h0, 8'h04);
        step(1);
        check("R8 settle after restart", 4'b1010, 16'h0, 8'h04);

        // R8: restart during vector fetch
        step(32);
        check("R8 at high vector", 4'b0011, 16'hFFFE, 8'h04);
        pulse(1'b1, 1'b0);
        check("R8 restart from vector", 4'b1110, 16'h0, 8'h02);
        step(66);
        check("R8 run after restarted sequence", 4'b0010, 16'h0, 8'h02);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule